// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Slice

This block is a behavioural model of a multiply-accumulate slice for a DSP datapath. Four 16-bit operands enter the slice. Each operand can pass through an optional register that has its own hold control. Operand A and operand B feed three multipliers:

- an 8x8 multiplier on their upper bytes,
- an 8x8 multiplier on their lower bytes,
- a full 16x16 multiplier with two optional pipeline stages.

Two 16-bit adder-subtractors, a top one and a bottom one, each drive an accumulator register. The 32-bit result is formed from a top half and a bottom half. Static parameters pick, for each half, the adder operands, the carry source and what reaches the result.

A typical configuration chains the carry of the bottom adder into the top adder, so the two halves act as one 32-bit accumulator of the 16x16 product. Another configuration uses the halves independently, as two 8x8 multipliers or as plain adders. The carry, accumulator-carry and sign-extension pins let several slices be placed in a cascade.

Top module: `mac_slice`

## Requirements
- R1: Bit i of IN_REG chooses whether an operand is registered (1) or passes straight through (0). The bit order is A=0, B=1, C=2, D=3. A registered operand loads when its hold input is 0 and keeps its value when its hold input is 1. Each accumulator also keeps its value while its own hold input is 1.
- R2: When `ce` is 0, no register in the slice changes, whatever the other inputs do.
- R3: Every reset acts on the next rising clock edge at which `ce` is 1, and clears to zero.
  - `rstInTop` clears the A and C registers and the upper 8x8 product register.
  - `rstInBot` clears the B and D registers, the lower 8x8 product register and both 16x16 pipeline registers.
  - `rstAccTop` and `rstAccBot` each clear only their own accumulator.
  - An accumulator reset wins over a load, and a load wins over hold and accumulation.
- R4: The output select of each half uses this encoding:
  - 0: the unregistered adder-subtractor sum
  - 1: the accumulator register
  - 2: that half's 8x8 product
  - 3: that half's 16 bits of the 16x16 product (upper bits for the top half, lower bits for the bottom half)
- R5: The select for the top X operand uses this encoding: 0 gives A, 1 gives the upper 8x8 product, 2 gives product bits [31:16], and 3 gives bit 15 of the bottom Z operand repeated 16 times. The select for the bottom Z operand uses this encoding: 0 gives B, 1 gives the lower 8x8 product, 2 gives product bits [15:0], and 3 gives `signExtIn` repeated 16 times. `signExtOut` carries bit 15 of the top X operand.
- R6: The top W operand is the top accumulator when TOP_W_SEL is 0 and C when it is 1. The bottom Y operand is the bottom accumulator when BOT_Y_SEL is 0 and D when it is 1.
- R7: The carry-in select uses this encoding:
  - 0: constant 0
  - 1: constant 1
  - 2: for the top adder, the registered carry of the bottom accumulator; for the bottom adder, `accumCarryIn`
  - 3: for the top adder, the bottom adder's live carry-out; for the bottom adder, `carryIn`
- R8: With its subtract control at 0, a half computes the 17-bit value W+X+cin. With the control at 1, it computes W−X−cin. Bit 16 of the top sum drives `carryOut`, and the registered bit 16 of the top sum drives `accumCarryOut`.
- R9: While `loadAccTop` is 1, the top accumulator takes the value of the effective C operand. While `loadAccBot` is 1, the bottom accumulator takes the effective D operand. The loaded carry bit is 0.
- R10: A_SIGNED and B_SIGNED decide whether A and B are read as two's complement in the 16x16 product and in the upper 8x8 product. The lower 8x8 product is always unsigned.
- R11: MUL_PIPE1 and MUL_PIPE2 each add one register stage, of one cycle, to the 16x16 product path.
- R12: With carry select 3 on the top half and carry select 0 on the bottom half, the two halves together accumulate or subtract the full 32-bit product modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| ce | input | 1 | Clock enable for every register |
| opA | input | 16 | Operand A |
| opB | input | 16 | Operand B |
| opC | input | 16 | Operand C |
| opD | input | 16 | Operand D |
| rstInTop | input | 1 | Clears A, C and the upper 8x8 product register |
| rstInBot | input | 1 | Clears B, D, the lower 8x8 product register and the 16x16 registers |
| rstAccTop | input | 1 | Clears the top accumulator |
| rstAccBot | input | 1 | Clears the bottom accumulator |
| holdA | input | 1 | Hold for the A register |
| holdB | input | 1 | Hold for the B register |
| holdC | input | 1 | Hold for the C register |
| holdD | input | 1 | Hold for the D register |
| holdAccTop | input | 1 | Hold for the top accumulator |
| holdAccBot | input | 1 | Hold for the bottom accumulator |
| subTop | input | 1 | Top half subtracts when 1 |
| subBot | input | 1 | Bottom half subtracts when 1 |
| loadAccTop | input | 1 | Load the top accumulator from C |
| loadAccBot | input | 1 | Load the bottom accumulator from D |
| accumCarryIn | input | 1 | Registered carry from the slice below |
| signExtIn | input | 1 | Sign-extension bit from the slice below |
| carryIn | input | 1 | Live carry from the slice below |
| result | output | 32 | {top half, bottom half} |
| carryOut | output | 1 | Live carry-out of the top adder |
| accumCarryOut | output | 1 | Registered carry of the top accumulator |
| signExtOut | output | 1 | Bit 15 of the top X operand |

## Verification
The bench targets the carry and borrow that cross from the bottom half into the top half. If that chain were broken, a negative signed product or a subtraction would leave the top half off by one, or would leave it unextended at 0x0000. Reset priority over load is driven with both inputs at 1. A design that ranks them the other way would show the C/D value instead of zero.

Cycles with the clock enable low and operand holds with changing inputs are exercised. A design that leaks there would keep accumulating. The cycle-accurate reference also tracks the register-plus-pipeline latency, so an extra or missing stage appears as a one-cycle shift in every accumulated value.

A second, unregistered instance covers the remaining configuration choices:

- unsigned 8x8 products, where a sign slip shows at 0xFF×0xFF;
- the constant-one carry;
- sign extension of bit 15 into the top adder, observed at `carryOut`.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

  typedef struct packed {
    logic en;
    logic ldA;
    logic ldB;
    logic ldC;
    logic ldD;
    logic clrInTop;
    logic clrInBot;
    logic clrAccTop;
    logic clrAccBot;
    logic ldAccTop;
    logic ldAccBot;
    logic updAccTop;
    logic updAccBot;
    logic subTop;
    logic subBot;
  } macStrobes_t;

  // 17-bit add/subtract: bit 16 is the carry (or borrow) out
  function automatic logic [16:0] addSub(input logic [15:0] w, input logic [15:0] x,
                                         input logic cin, input logic sub);
    if (sub) return {1'b0, w} - {1'b0, x} - {16'b0, cin};
    else     return {1'b0, w} + {1'b0, x} + {16'b0, cin};
  endfunction

endpackage

// File: rtl/mac_opt_reg.sv
module mac_opt_reg #(
  parameter int WIDTH = 16,
  parameter bit REGISTERED = 1'b0
) (
  input  logic             clk,
  input  logic             ld,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (REGISTERED) begin : g_reg
      logic [WIDTH-1:0] qReg;
      always_ff @(posedge clk) begin
        if (clr)     qReg <= '0;
        else if (ld) qReg <= d;
      end
      assign q = qReg;

      p_hold_keeps_r1: assert property (@(posedge clk) disable iff (clr)
        !ld |=> $stable(qReg))
        else $error("register changed without a load strobe");
      p_clear_zero_r3: assert property (@(posedge clk) disable iff (ld && !clr)
        clr |=> (qReg == '0))
        else $error("register not cleared");
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_slice_pkg::*;
(
  input  logic        clk,
  input  logic        ce,
  input  logic        rstInTop,
  input  logic        rstInBot,
  input  logic        rstAccTop,
  input  logic        rstAccBot,
  input  logic        holdA,
  input  logic        holdB,
  input  logic        holdC,
  input  logic        holdD,
  input  logic        holdAccTop,
  input  logic        holdAccBot,
  input  logic        subTop,
  input  logic        subBot,
  input  logic        loadAccTop,
  input  logic        loadAccBot,
  output macStrobes_t st
);
  always_comb begin
    st.en        = ce;
    st.clrInTop  = ce & rstInTop;
    st.clrInBot  = ce & rstInBot;
    st.ldA       = ce & ~rstInTop & ~holdA;
    st.ldC       = ce & ~rstInTop & ~holdC;
    st.ldB       = ce & ~rstInBot & ~holdB;
    st.ldD       = ce & ~rstInBot & ~holdD;
    st.clrAccTop = ce & rstAccTop;
    st.clrAccBot = ce & rstAccBot;
    st.ldAccTop  = ce & ~rstAccTop & loadAccTop;
    st.ldAccBot  = ce & ~rstAccBot & loadAccBot;
    st.updAccTop = ce & ~rstAccTop & ~loadAccTop & ~holdAccTop;
    st.updAccBot = ce & ~rstAccBot & ~loadAccBot & ~holdAccBot;
    st.subTop    = subTop;
    st.subBot    = subBot;
  end

  p_acc_top_one_action_r3: assert property (@(posedge clk) disable iff (!ce)
    $onehot0({st.clrAccTop, st.ldAccTop, st.updAccTop}))
    else $error("top accumulator strobes overlap");
  p_acc_bot_one_action_r3: assert property (@(posedge clk) disable iff (!ce)
    $onehot0({st.clrAccBot, st.ldAccBot, st.updAccBot}))
    else $error("bottom accumulator strobes overlap");
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_slice_pkg::*;
#(
  parameter int       HALF_W      = 16,
  parameter bit [3:0] IN_REG      = 4'b0000,
  parameter bit       TOP8_REG    = 1'b0,
  parameter bit       BOT8_REG    = 1'b0,
  parameter bit       MUL_PIPE1   = 1'b0,
  parameter bit       MUL_PIPE2   = 1'b0,
  parameter bit [1:0] TOP_OUT_SEL = 2'd0,
  parameter bit [1:0] TOP_X_SEL   = 2'd0,
  parameter bit       TOP_W_SEL   = 1'b0,
  parameter bit [1:0] TOP_CI_SEL  = 2'd0,
  parameter bit [1:0] BOT_OUT_SEL = 2'd0,
  parameter bit [1:0] BOT_Z_SEL   = 2'd0,
  parameter bit       BOT_Y_SEL   = 1'b0,
  parameter bit [1:0] BOT_CI_SEL  = 2'd0,
  parameter bit       A_SIGNED    = 1'b0,
  parameter bit       B_SIGNED    = 1'b0
) (
  input  logic                clk,
  input  macStrobes_t         st,
  input  logic [HALF_W-1:0]   opA,
  input  logic [HALF_W-1:0]   opB,
  input  logic [HALF_W-1:0]   opC,
  input  logic [HALF_W-1:0]   opD,
  input  logic                accumCarryIn,
  input  logic                signExtIn,
  input  logic                carryIn,
  output logic [2*HALF_W-1:0] result,
  output logic                carryOut,
  output logic                accumCarryOut,
  output logic                signExtOut
);
  localparam int BYTE_W = HALF_W / 2;
  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] opIn  [4];
  logic [HALF_W-1:0] opEff [4];
  logic [3:0] ldVec, clrVec;

  assign opIn[0] = opA;
  assign opIn[1] = opB;
  assign opIn[2] = opC;
  assign opIn[3] = opD;
  assign ldVec  = {st.ldD, st.ldC, st.ldB, st.ldA};
  assign clrVec = {st.clrInBot, st.clrInTop, st.clrInBot, st.clrInTop};

  for (genvar i = 0; i < 4; i++) begin : g_op
    mac_opt_reg #(.WIDTH(HALF_W), .REGISTERED(IN_REG[i])) u_opReg (
      .clk(clk), .ld(ldVec[i]), .clr(clrVec[i]), .d(opIn[i]), .q(opEff[i]));
  end

  logic [HALF_W-1:0] aOp, bOp, cOp, dOp;
  assign aOp = opEff[0];
  assign bOp = opEff[1];
  assign cOp = opEff[2];
  assign dOp = opEff[3];

  // multipliers
  logic aSgn, bSgn;
  logic [FULL_W-1:0] aWide, bWide, p16Raw, p16Mid, p16Fin;
  logic [HALF_W-1:0] aHi, bHi, aLo, bLo, top8Raw, bot8Raw, top8Fin, bot8Fin;

  assign aSgn    = A_SIGNED & aOp[HALF_W-1];
  assign bSgn    = B_SIGNED & bOp[HALF_W-1];
  assign aWide   = {{(FULL_W-HALF_W){aSgn}}, aOp};
  assign bWide   = {{(FULL_W-HALF_W){bSgn}}, bOp};
  assign p16Raw  = aWide * bWide;
  assign aHi     = {{(HALF_W-BYTE_W){aSgn}}, aOp[HALF_W-1:BYTE_W]};
  assign bHi     = {{(HALF_W-BYTE_W){bSgn}}, bOp[HALF_W-1:BYTE_W]};
  assign aLo     = {{(HALF_W-BYTE_W){1'b0}}, aOp[BYTE_W-1:0]};
  assign bLo     = {{(HALF_W-BYTE_W){1'b0}}, bOp[BYTE_W-1:0]};
  assign top8Raw = aHi * bHi;
  assign bot8Raw = aLo * bLo;

  mac_opt_reg #(.WIDTH(HALF_W), .REGISTERED(TOP8_REG)) u_top8Reg (
    .clk(clk), .ld(st.en), .clr(st.clrInTop), .d(top8Raw), .q(top8Fin));
  mac_opt_reg #(.WIDTH(HALF_W), .REGISTERED(BOT8_REG)) u_bot8Reg (
    .clk(clk), .ld(st.en), .clr(st.clrInBot), .d(bot8Raw), .q(bot8Fin));
  mac_opt_reg #(.WIDTH(FULL_W), .REGISTERED(MUL_PIPE1)) u_mulPipe1 (
    .clk(clk), .ld(st.en), .clr(st.clrInBot), .d(p16Raw), .q(p16Mid));
  mac_opt_reg #(.WIDTH(FULL_W), .REGISTERED(MUL_PIPE2)) u_mulPipe2 (
    .clk(clk), .ld(st.en), .clr(st.clrInBot), .d(p16Mid), .q(p16Fin));

  // adder-subtractors and accumulators
  logic [HALF_W-1:0] accTop, accBot, xOp, wOp, zOp, yOp;
  logic              accCoTop, accCoBot, topCin, botCin;
  logic [HALF_W:0]   topSum, botSum;

  always_comb begin
    case (BOT_Z_SEL)
      2'd0:    zOp = bOp;
      2'd1:    zOp = bot8Fin;
      2'd2:    zOp = p16Fin[HALF_W-1:0];
      default: zOp = {HALF_W{signExtIn}};
    endcase
    case (TOP_X_SEL)
      2'd0:    xOp = aOp;
      2'd1:    xOp = top8Fin;
      2'd2:    xOp = p16Fin[FULL_W-1:HALF_W];
      default: xOp = {HALF_W{zOp[HALF_W-1]}};
    endcase
    yOp = BOT_Y_SEL ? dOp : accBot;
    wOp = TOP_W_SEL ? cOp : accTop;
    case (BOT_CI_SEL)
      2'd0:    botCin = 1'b0;
      2'd1:    botCin = 1'b1;
      2'd2:    botCin = accumCarryIn;
      default: botCin = carryIn;
    endcase
    botSum = addSub(yOp, zOp, botCin, st.subBot);
    case (TOP_CI_SEL)
      2'd0:    topCin = 1'b0;
      2'd1:    topCin = 1'b1;
      2'd2:    topCin = accCoBot;
      default: topCin = botSum[HALF_W];
    endcase
    topSum = addSub(wOp, xOp, topCin, st.subTop);
  end

  always_ff @(posedge clk) begin
    if (st.clrAccTop)      {accCoTop, accTop} <= '0;
    else if (st.ldAccTop)  {accCoTop, accTop} <= {1'b0, cOp};
    else if (st.updAccTop) {accCoTop, accTop} <= topSum;
  end

  always_ff @(posedge clk) begin
    if (st.clrAccBot)      {accCoBot, accBot} <= '0;
    else if (st.ldAccBot)  {accCoBot, accBot} <= {1'b0, dOp};
    else if (st.updAccBot) {accCoBot, accBot} <= botSum;
  end

  // output selection
  logic [HALF_W-1:0] outTop, outBot;
  always_comb begin
    case (TOP_OUT_SEL)
      2'd0:    outTop = topSum[HALF_W-1:0];
      2'd1:    outTop = accTop;
      2'd2:    outTop = top8Fin;
      default: outTop = p16Fin[FULL_W-1:HALF_W];
    endcase
    case (BOT_OUT_SEL)
      2'd0:    outBot = botSum[HALF_W-1:0];
      2'd1:    outBot = accBot;
      2'd2:    outBot = bot8Fin;
      default: outBot = p16Fin[HALF_W-1:0];
    endcase
  end

  assign result        = {outTop, outBot};
  assign carryOut      = topSum[HALF_W];
  assign accumCarryOut = accCoTop;
  assign signExtOut    = xOp[HALF_W-1];

  p_freeze_on_ce_low_r2: assert property (@(posedge clk) disable iff (st.en)
    !st.en |=> ($stable(accTop) && $stable(accBot)))
    else $error("accumulator moved with clock enable low");
  p_acc_top_clear_r3: assert property (@(posedge clk) disable iff (!st.en)
    st.clrAccTop |=> (accTop == '0))
    else $error("top accumulator not cleared");
  p_acc_top_load_r9: assert property (@(posedge clk) disable iff (st.clrAccTop)
    st.ldAccTop |=> (accTop == $past(cOp)))
    else $error("top accumulator not loaded from C");
  p_acc_bot_load_r9: assert property (@(posedge clk) disable iff (st.clrAccBot)
    st.ldAccBot |=> (accBot == $past(dOp)))
    else $error("bottom accumulator not loaded from D");
  p_acc_hold_r1: assert property (@(posedge clk) disable iff (st.clrAccBot)
    (!st.ldAccBot && !st.updAccBot) |=> $stable(accBot))
    else $error("bottom accumulator moved while held");
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int       HALF_W      = 16,
  parameter bit [3:0] IN_REG      = 4'b0000,
  parameter bit       TOP8_REG    = 1'b0,
  parameter bit       BOT8_REG    = 1'b0,
  parameter bit       MUL_PIPE1   = 1'b0,
  parameter bit       MUL_PIPE2   = 1'b0,
  parameter bit [1:0] TOP_OUT_SEL = 2'd0,
  parameter bit [1:0] TOP_X_SEL   = 2'd0,
  parameter bit       TOP_W_SEL   = 1'b0,
  parameter bit [1:0] TOP_CI_SEL  = 2'd0,
  parameter bit [1:0] BOT_OUT_SEL = 2'd0,
  parameter bit [1:0] BOT_Z_SEL   = 2'd0,
  parameter bit       BOT_Y_SEL   = 1'b0,
  parameter bit [1:0] BOT_CI_SEL  = 2'd0,
  parameter bit       A_SIGNED    = 1'b0,
  parameter bit       B_SIGNED    = 1'b0
) (
  input  logic                clk,
  input  logic                ce,
  input  logic [HALF_W-1:0]   opA,
  input  logic [HALF_W-1:0]   opB,
  input  logic [HALF_W-1:0]   opC,
  input  logic [HALF_W-1:0]   opD,
  input  logic                rstInTop,
  input  logic                rstInBot,
  input  logic                rstAccTop,
  input  logic                rstAccBot,
  input  logic                holdA,
  input  logic                holdB,
  input  logic                holdC,
  input  logic                holdD,
  input  logic                holdAccTop,
  input  logic                holdAccBot,
  input  logic                subTop,
  input  logic                subBot,
  input  logic                loadAccTop,
  input  logic                loadAccBot,
  input  logic                accumCarryIn,
  input  logic                signExtIn,
  input  logic                carryIn,
  output logic [2*HALF_W-1:0] result,
  output logic                carryOut,
  output logic                accumCarryOut,
  output logic                signExtOut
);
  macStrobes_t st;

  mac_ctrl u_ctrl (
    .clk(clk), .ce(ce),
    .rstInTop(rstInTop), .rstInBot(rstInBot),
    .rstAccTop(rstAccTop), .rstAccBot(rstAccBot),
    .holdA(holdA), .holdB(holdB), .holdC(holdC), .holdD(holdD),
    .holdAccTop(holdAccTop), .holdAccBot(holdAccBot),
    .subTop(subTop), .subBot(subBot),
    .loadAccTop(loadAccTop), .loadAccBot(loadAccBot),
    .st(st));

  mac_datapath #(
    .HALF_W(HALF_W), .IN_REG(IN_REG), .TOP8_REG(TOP8_REG), .BOT8_REG(BOT8_REG),
    .MUL_PIPE1(MUL_PIPE1), .MUL_PIPE2(MUL_PIPE2),
    .TOP_OUT_SEL(TOP_OUT_SEL), .TOP_X_SEL(TOP_X_SEL), .TOP_W_SEL(TOP_W_SEL),
    .TOP_CI_SEL(TOP_CI_SEL), .BOT_OUT_SEL(BOT_OUT_SEL), .BOT_Z_SEL(BOT_Z_SEL),
    .BOT_Y_SEL(BOT_Y_SEL), .BOT_CI_SEL(BOT_CI_SEL),
    .A_SIGNED(A_SIGNED), .B_SIGNED(B_SIGNED)
  ) u_dp (
    .clk(clk), .st(st),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .accumCarryIn(accumCarryIn), .signExtIn(signExtIn), .carryIn(carryIn),
    .result(result), .carryOut(carryOut),
    .accumCarryOut(accumCarryOut), .signExtOut(signExtOut));
endmodule

// File: tb/tb_mac_slice.sv
`timescale 1ns/1ps
module tb_mac_slice;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // stimulus for the accumulating instance
  logic ce = 1'b1;
  logic [15:0] opA = '0, opB = '0, opC = '0, opD = '0;
  logic rstInTop = 1'b0, rstInBot = 1'b0, rstAccTop = 1'b0, rstAccBot = 1'b0;
  logic holdA = 1'b0, holdB = 1'b0, holdC = 1'b0, holdD = 1'b0;
  logic holdAccTop = 1'b0, holdAccBot = 1'b0, subTop = 1'b0, subBot = 1'b0;
  logic loadAccTop = 1'b0, loadAccBot = 1'b0;
  logic [31:0] result;
  logic carryOut, accumCarryOut, signExtOut;

  // 32-bit signed MAC: registered inputs, one product stage, registered outputs
  mac_slice #(
    .IN_REG(4'b1111), .MUL_PIPE2(1'b1),
    .TOP_OUT_SEL(2'd1), .TOP_X_SEL(2'd2), .TOP_W_SEL(1'b0), .TOP_CI_SEL(2'd3),
    .BOT_OUT_SEL(2'd1), .BOT_Z_SEL(2'd2), .BOT_Y_SEL(1'b0), .BOT_CI_SEL(2'd0),
    .A_SIGNED(1'b1), .B_SIGNED(1'b1)
  ) dut (
    .clk(clk), .ce(ce), .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .rstInTop(rstInTop), .rstInBot(rstInBot), .rstAccTop(rstAccTop), .rstAccBot(rstAccBot),
    .holdA(holdA), .holdB(holdB), .holdC(holdC), .holdD(holdD),
    .holdAccTop(holdAccTop), .holdAccBot(holdAccBot), .subTop(subTop), .subBot(subBot),
    .loadAccTop(loadAccTop), .loadAccBot(loadAccBot),
    .accumCarryIn(1'b0), .signExtIn(1'b0), .carryIn(1'b0),
    .result(result), .carryOut(carryOut), .accumCarryOut(accumCarryOut),
    .signExtOut(signExtOut));

  // combinational instance: top = upper 8x8 product, bottom = D +/- B + 1
  logic [15:0] bA = '0, bB = '0, bC = '0, bD = '0;
  logic bSub = 1'b0;
  logic [31:0] bResult;
  logic bCarry, bAccCo, bSext;
  mac_slice #(
    .IN_REG(4'b0000),
    .TOP_OUT_SEL(2'd2), .TOP_X_SEL(2'd3), .TOP_W_SEL(1'b1), .TOP_CI_SEL(2'd0),
    .BOT_OUT_SEL(2'd0), .BOT_Z_SEL(2'd0), .BOT_Y_SEL(1'b1), .BOT_CI_SEL(2'd1)
  ) dutComb (
    .clk(clk), .ce(1'b1), .opA(bA), .opB(bB), .opC(bC), .opD(bD),
    .rstInTop(1'b0), .rstInBot(1'b0), .rstAccTop(1'b0), .rstAccBot(1'b0),
    .holdA(1'b0), .holdB(1'b0), .holdC(1'b0), .holdD(1'b0),
    .holdAccTop(1'b0), .holdAccBot(1'b0), .subTop(1'b0), .subBot(bSub),
    .loadAccTop(1'b0), .loadAccBot(1'b0),
    .accumCarryIn(1'b0), .signExtIn(1'b0), .carryIn(1'b0),
    .result(bResult), .carryOut(bCarry), .accumCarryOut(bAccCo),
    .signExtOut(bSext));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] expQ[$];
  string tagQ[$];
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      automatic logic [31:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      chk(t, result, e);
    end
  end

  // reference state derived from the requirements
  logic [15:0] mA = '0, mB = '0, mC = '0, mD = '0, mAccTop = '0, mAccBot = '0;
  logic [31:0] mP = '0;

  task automatic tick(string tag);
    @(posedge clk);
    #1;
    if (ce) begin
      automatic logic signed [31:0] pr = $signed(mA) * $signed(mB);
      automatic logic [16:0] bs, ts;
      automatic logic [15:0] nTop = mAccTop, nBot = mAccBot;
      bs = subBot ? ({1'b0, mAccBot} - {1'b0, mP[15:0]})
                  : ({1'b0, mAccBot} + {1'b0, mP[15:0]});
      ts = subTop ? ({1'b0, mAccTop} - {1'b0, mP[31:16]} - {16'b0, bs[16]})
                  : ({1'b0, mAccTop} + {1'b0, mP[31:16]} + {16'b0, bs[16]});
      if (rstAccTop)       nTop = '0;
      else if (loadAccTop) nTop = mC;
      else if (!holdAccTop) nTop = ts[15:0];
      if (rstAccBot)       nBot = '0;
      else if (loadAccBot) nBot = mD;
      else if (!holdAccBot) nBot = bs[15:0];
      mP = rstInBot ? 32'h0 : pr;
      if (rstInTop) begin mA = '0; mC = '0; end
      else begin
        if (!holdA) mA = opA;
        if (!holdC) mC = opC;
      end
      if (rstInBot) begin mB = '0; mD = '0; end
      else begin
        if (!holdB) mB = opB;
        if (!holdD) mD = opD;
      end
      mAccTop = nTop;
      mAccBot = nBot;
    end
    expQ.push_back({mAccTop, mAccBot});
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    // R3: reset everything
    {rstInTop, rstInBot, rstAccTop, rstAccBot} = 4'hF;
    tick("R3 reset state");
    tick("R3 reset state");
    {rstInTop, rstInBot, rstAccTop, rstAccBot} = 4'h0;

    // R11/R1: latency through input register and product stage
    opA = 16'd3; opB = 16'd5;
    for (int i = 0; i < 5; i++) tick("R11 pipeline latency of accumulation");

    // R9 + R3: load from C/D with hold also set
    opC = 16'h0001; opD = 16'hFFF0; opA = 16'd0; opB = 16'd0;
    tick("R1 C/D register load");
    loadAccTop = 1'b1; loadAccBot = 1'b1; holdAccTop = 1'b1; holdAccBot = 1'b1;
    tick("R9 load wins over hold");
    loadAccTop = 1'b0; loadAccBot = 1'b0; holdAccTop = 1'b0; holdAccBot = 1'b0;

    // R10/R12: signed negative product with carry across halves
    opA = 16'hFFFE; opB = 16'd7;
    for (int i = 0; i < 5; i++) tick("R10 R12 signed product accumulation");

    // R8: subtract in both halves (borrow crosses halves)
    subTop = 1'b1; subBot = 1'b1; opA = 16'd300; opB = 16'd400;
    for (int i = 0; i < 5; i++) tick("R8 subtract with borrow");
    subTop = 1'b0; subBot = 1'b0;

    // R1: hold operand A while its input changes
    holdA = 1'b1; opA = 16'h1234;
    for (int i = 0; i < 4; i++) tick("R1 operand hold");
    holdA = 1'b0;

    // R2: clock enable low freezes everything
    ce = 1'b0; opA = 16'h7777; opB = 16'h0101; loadAccTop = 1'b1;
    {rstAccTop, rstAccBot} = 2'b11;
    for (int i = 0; i < 4; i++) tick("R2 clock enable low");
    ce = 1'b1; loadAccTop = 1'b0; {rstAccTop, rstAccBot} = 2'b00;

    // R3: accumulator reset beats load; partial input reset
    opC = 16'hABCD; opD = 16'h1357;
    tick("R3 operand settle");
    rstAccBot = 1'b1; loadAccBot = 1'b1; loadAccTop = 1'b1;
    tick("R3 reset over load");
    rstAccBot = 1'b0; loadAccBot = 1'b0; loadAccTop = 1'b0;
    rstInTop = 1'b1;
    for (int i = 0; i < 3; i++) tick("R3 top input reset clears A");
    rstInTop = 1'b0;

    // mixed traffic
    for (int i = 0; i < 80; i++) begin
      opA = 16'($urandom); opB = 16'($urandom); opC = 16'($urandom); opD = 16'($urandom);
      holdA = ($urandom % 4) == 0; holdB = ($urandom % 4) == 0;
      holdC = ($urandom % 4) == 0; holdD = ($urandom % 4) == 0;
      holdAccTop = ($urandom % 5) == 0; holdAccBot = ($urandom % 5) == 0;
      subTop = ($urandom % 3) == 0; subBot = ($urandom % 3) == 0;
      loadAccTop = ($urandom % 9) == 0; loadAccBot = ($urandom % 9) == 0;
      rstAccTop = ($urandom % 17) == 0; rstAccBot = ($urandom % 17) == 0;
      rstInTop = ($urandom % 19) == 0; rstInBot = ($urandom % 19) == 0;
      ce = ($urandom % 6) != 0;
      tick("R12 mixed control traffic");
    end
    {holdA, holdB, holdC, holdD, holdAccTop, holdAccBot} = '0;
    {subTop, subBot, loadAccTop, loadAccBot, rstAccTop, rstAccBot, rstInTop, rstInBot} = '0;
    ce = 1'b1;
    tick("R12 drain");
    tick("R12 drain");

    // combinational instance
    bA = 16'hFF12; bB = 16'hFF34; bD = 16'h1000; bC = 16'h0001; bSub = 1'b0;
    #1;
    chk("R10 unsigned upper 8x8 (R4 select 2)", {16'h0, bResult[31:16]}, 32'h0000FE01);
    chk("R4 unregistered bottom sum D+B+1 (R6 R7)", {16'h0, bResult[15:0]},
        {16'h0, 16'h1000 + 16'hFF34 + 16'd1});
    bB = 16'h8000;
    #1;
    chk("R5 sign extension of Z bit 15 carries out", {31'h0, bCarry}, 32'd1);
    chk("R5 signExtOut follows X bit 15", {31'h0, bSext}, 32'd1);
    bB = 16'h0001;
    #1;
    chk("R5 no sign extension when Z bit 15 is 0", {31'h0, bCarry}, 32'd0);
    bSub = 1'b1;
    #1;
    chk("R8 subtract D-B-1", {16'h0, bResult[15:0]}, 32'h00000FFE);
    bA = 16'h0203; bB = 16'h0405;
    #1;
    chk("R1 unregistered operands pass straight to 8x8", {16'h0, bResult[31:16]}, 32'd8);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule